// File: doc/BRIEF.md
# Halftone Pattern, Raster Operation and Edge Mask Word Combiner

This block is the per-word datapath of a bit-block transfer engine. Each cycle it can take one aligned source word and the destination word already fetched from memory. It produces the word to store back at the destination address. First, a pattern word is chosen or built: it is all ones, a row of a small pattern memory, the source word, or the source word masked by that row. The pattern word and the destination word then go through one of sixteen two-input boolean functions. Last, an edge mask keeps the bits of the destination word that lie outside the rectangle being drawn.

The pattern memory has sixteen rows and is loaded through a simple write port. It is read by row index. The index normally comes from the low bits of a line counter supplied by the sequencer. In smudge mode the index comes from the source word itself, so the image selects its own fill pattern. The edge mask is one of three masks, picked by the word's place in the line: the first word, a middle word or the last word. The result is registered. A valid flag follows the input valid by one cycle. The sequencer supplies addresses, memory traffic and the line and word positions.

Top module: `blit_word_combiner`

## Requirements
- R1: The pattern select `ht_sel` forms the pattern word H as follows: 0 gives all ones, 1 gives the pattern row, 2 gives the source word, and 3 gives the source word AND the pattern row.
- R2: The pattern row index is `line_idx[3:0]` when `smudge` is 0. It is `src_word[3:0]` when `smudge` is 1.
- R3: With D the destination word, the 4-bit `rop` gives this result: 0:0, 1:H&D, 2:H&~D, 3:H, 4:~H&D, 5:D, 6:H^D, 7:H|D, 8:~H&~D, 9:~H^D, A:~D, B:H|~D, C:~H, D:~H|D, E:~H|~D, F:all ones.
- R4: A word with `first_word`=1 uses `mask_first`, even when `last_word` is also 1. A word with only `last_word`=1 uses `mask_last`. Any other word uses `mask_mid`.
- R5: Each output bit takes the raster result where the selected mask bit is 1. Where the mask bit is 0, it keeps the destination bit.
- R6: `out_valid` equals `in_valid` from the previous cycle. `out_word` loads the combined result of an accepted word at that edge. While `in_valid` is 0, `out_word` holds its value.
- R7: While `rst` is 1 at a clock edge, `out_valid` and `out_word` become 0.
- R8: Asserting `pat_we` writes `pat_wdata` into row `pat_addr` at the clock edge. A word presented in the same cycle sees the old contents of that row. Words presented in later cycles see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_we | input | 1 | Pattern memory write enable |
| pat_addr | input | 4 | Pattern memory row to write |
| pat_wdata | input | 16 | Pattern row data |
| in_valid | input | 1 | Word inputs are valid this cycle |
| src_word | input | 16 | Aligned source word |
| dst_word | input | 16 | Destination word read from memory |
| line_idx | input | 4 | Line counter used as the pattern row index |
| smudge | input | 1 | Index the pattern by source bits instead |
| ht_sel | input | 2 | Pattern word select |
| rop | input | 4 | Boolean function code |
| first_word | input | 1 | Word is first in its line |
| last_word | input | 1 | Word is last in its line |
| mask_first | input | 16 | Edge mask for the first word |
| mask_mid | input | 16 | Edge mask for middle words |
| mask_last | input | 16 | Edge mask for the last word |
| out_valid | output | 1 | Registered result valid |
| out_word | output | 16 | Registered word to write back |

## Verification
The bench goes after a one-word line with both position flags set. A design that checks the last position first would apply the wrong mask to that word and change bits outside the edge. Smudge mode is driven with a line index and source low bits that differ. If the row index were taken from the wrong field, a different pattern row would appear. Every one of the sixteen function codes is run with fixed operands that set all four input combinations, so a swapped operand or a dropped inversion shows up as wrong bits. A pattern row is also rewritten in the same cycle it is read, to show that the word still sees the old row; a bypass of the write data would show the new row too early.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef enum logic [1:0] {
    HT_ONES = 2'd0,
    HT_PAT  = 2'd1,
    HT_SRC  = 2'd2,
    HT_BOTH = 2'd3
  } ht_sel_e;
endpackage

// File: rtl/blit_pattern_ram.sv
module blit_pattern_ram #(
  parameter int WORD_W   = 16,
  parameter int ROW_BITS = 4
) (
  input  logic                clk,
  input  logic                we,
  input  logic [ROW_BITS-1:0] waddr,
  input  logic [WORD_W-1:0]   wdata,
  input  logic [ROW_BITS-1:0] raddr,
  output logic [WORD_W-1:0]   rdata
);
  localparam int ROWS = 1 << ROW_BITS;

  logic [WORD_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/blit_pattern_sel.sv
module blit_pattern_sel
  import blit_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int ROW_BITS = 4
) (
  input  logic                rst,
  input  logic [WORD_W-1:0]   src,
  input  logic [ROW_BITS-1:0] line_idx,
  input  logic                smudge,
  input  logic [1:0]          sel,
  input  logic [WORD_W-1:0]   row_data,
  output logic [ROW_BITS-1:0] row_idx,
  output logic [WORD_W-1:0]   hword
);
  assign row_idx = smudge ? src[ROW_BITS-1:0] : line_idx;

  always_comb begin
    unique case (ht_sel_e'(sel))
      HT_ONES: hword = '1;
      HT_PAT:  hword = row_data;
      HT_SRC:  hword = src;
      HT_BOTH: hword = src & row_data;
    endcase
  end

  // R1: a source-only select passes the source word through unchanged
  always_comb begin
    if (!rst && sel == 2'd2)
      a_r1_src_pass : assert (hword == src);
  end
  // R1: the combined select never sets a bit that the source word lacks
  always_comb begin
    if (!rst && sel == 2'd3)
      a_r1_both_subset : assert ((hword & ~src) == '0);
  end
endmodule

// File: rtl/blit_rop.sv
module blit_rop #(
  parameter int WORD_W = 16
) (
  input  logic              rst,
  input  logic [3:0]        code,
  input  logic [WORD_W-1:0] h,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] res
);
  // Each code bit is the output for one (H,D) pair: bit {~H,~D}
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign res[i] = code[{~h[i], ~d[i]}];
  end

  // R3: the copy code yields H and the no-op code yields D
  always_comb begin
    if (!rst && code == 4'h3)
      a_r3_copy_h : assert (res == h);
    if (!rst && code == 4'h5)
      a_r3_keep_d : assert (res == d);
    if (!rst && code == 4'h6)
      a_r3_xor : assert (res == (h ^ d));
  end
endmodule

// File: rtl/blit_edge_merge.sv
module blit_edge_merge #(
  parameter int WORD_W = 16
) (
  input  logic              rst,
  input  logic              first,
  input  logic              last,
  input  logic [WORD_W-1:0] m_first,
  input  logic [WORD_W-1:0] m_mid,
  input  logic [WORD_W-1:0] m_last,
  input  logic [WORD_W-1:0] opres,
  input  logic [WORD_W-1:0] dst,
  output logic [WORD_W-1:0] mask,
  output logic [WORD_W-1:0] merged
);
  always_comb begin
    if (first)     mask = m_first;
    else if (last) mask = m_last;
    else           mask = m_mid;
  end

  for (genvar i = 0; i < WORD_W; i++) begin : g_mux
    assign merged[i] = mask[i] ? opres[i] : dst[i];
  end

  // R4: a one-word line uses the first-word mask
  always_comb begin
    if (!rst && first && last)
      a_r4_first_wins : assert (mask == m_first);
  end
  // R5: bits outside the mask keep the destination value
  always_comb begin
    if (!rst)
      a_r5_outside_kept : assert (((merged ^ dst) & ~mask) == '0);
  end
endmodule

// File: rtl/blit_word_combiner.sv
module blit_word_combiner #(
  parameter int WORD_W   = 16,
  parameter int ROW_BITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pat_we,
  input  logic [ROW_BITS-1:0] pat_addr,
  input  logic [WORD_W-1:0]   pat_wdata,
  input  logic                in_valid,
  input  logic [WORD_W-1:0]   src_word,
  input  logic [WORD_W-1:0]   dst_word,
  input  logic [ROW_BITS-1:0] line_idx,
  input  logic                smudge,
  input  logic [1:0]          ht_sel,
  input  logic [3:0]          rop,
  input  logic                first_word,
  input  logic                last_word,
  input  logic [WORD_W-1:0]   mask_first,
  input  logic [WORD_W-1:0]   mask_mid,
  input  logic [WORD_W-1:0]   mask_last,
  output logic                out_valid,
  output logic [WORD_W-1:0]   out_word
);
  logic [ROW_BITS-1:0] row_idx;
  logic [WORD_W-1:0]   row_data, hword, opres, mask, merged;

  blit_pattern_ram #(.WORD_W(WORD_W), .ROW_BITS(ROW_BITS)) u_ram (
    .clk(clk), .we(pat_we), .waddr(pat_addr), .wdata(pat_wdata),
    .raddr(row_idx), .rdata(row_data)
  );

  blit_pattern_sel #(.WORD_W(WORD_W), .ROW_BITS(ROW_BITS)) u_sel (
    .rst(rst), .src(src_word), .line_idx(line_idx), .smudge(smudge),
    .sel(ht_sel), .row_data(row_data), .row_idx(row_idx), .hword(hword)
  );

  blit_rop #(.WORD_W(WORD_W)) u_rop (
    .rst(rst), .code(rop), .h(hword), .d(dst_word), .res(opres)
  );

  blit_edge_merge #(.WORD_W(WORD_W)) u_merge (
    .rst(rst), .first(first_word), .last(last_word),
    .m_first(mask_first), .m_mid(mask_mid), .m_last(mask_last),
    .opres(opres), .dst(dst_word), .mask(mask), .merged(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= merged;
    end
  end

  // R6: valid follows the input valid by one cycle
  a_r6_valid_lag : assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r6_idle_lag : assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R6: the result holds while no word is accepted
  a_r6_hold : assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_word));
  // R7: reset clears the outputs
  a_r7_reset : assert property (@(posedge clk)
    rst |=> (!out_valid && out_word == '0));
endmodule

// File: tb/sim_blit_word_combiner.sv
module sim_blit_word_combiner;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic pat_we;
  logic [3:0] pat_addr;
  logic [15:0] pat_wdata;
  logic in_valid;
  logic [15:0] src_word, dst_word, mask_first, mask_mid, mask_last;
  logic [3:0] line_idx, rop;
  logic smudge, first_word, last_word;
  logic [1:0] ht_sel;
  logic out_valid;
  logic [15:0] out_word;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [15:0] pat [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  blit_word_combiner u0 (
    .clk(clk), .rst(rst), .pat_we(pat_we), .pat_addr(pat_addr),
    .pat_wdata(pat_wdata), .in_valid(in_valid), .src_word(src_word),
    .dst_word(dst_word), .line_idx(line_idx), .smudge(smudge),
    .ht_sel(ht_sel), .rop(rop), .first_word(first_word),
    .last_word(last_word), .mask_first(mask_first), .mask_mid(mask_mid),
    .mask_last(mask_last), .out_valid(out_valid), .out_word(out_word)
  );

  function automatic logic [15:0] ref_h(logic [15:0] s, logic [3:0] li,
                                        logic sm, logic [1:0] hs);
    logic [15:0] row;
    row = pat[sm ? s[3:0] : li];
    case (hs)
      2'd0: return 16'hFFFF;
      2'd1: return row;
      2'd2: return s;
      default: return s & row;
    endcase
  endfunction

  function automatic logic [15:0] ref_op(logic [3:0] c, logic [15:0] h,
                                         logic [15:0] d);
    case (c)
      4'h0: return 16'h0000;
      4'h1: return h & d;
      4'h2: return h & ~d;
      4'h3: return h;
      4'h4: return ~h & d;
      4'h5: return d;
      4'h6: return h ^ d;
      4'h7: return h | d;
      4'h8: return ~h & ~d;
      4'h9: return ~(h ^ d);
      4'hA: return ~d;
      4'hB: return h | ~d;
      4'hC: return ~h;
      4'hD: return ~h | d;
      4'hE: return ~h | ~d;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [15:0] ref_word();
    logic [15:0] m, r;
    m = first_word ? mask_first : (last_word ? mask_last : mask_mid);
    r = ref_op(rop, ref_h(src_word, line_idx, smudge, ht_sel), dst_word);
    return (r & m) | (dst_word & ~m);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    in_valid = 0; pat_we = 0;
  endtask

  // drive a word at a negedge, check the registered result one cycle later
  task automatic run_word(string req, logic [15:0] exp);
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check(req, out_word, exp);
    check({req, " valid"}, {15'd0, out_valid}, 16'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; idle();
    pat_addr = 0; pat_wdata = 0; src_word = 0; dst_word = 0;
    line_idx = 0; smudge = 0; ht_sel = 0; rop = 0;
    first_word = 0; last_word = 0;
    mask_first = 0; mask_mid = 0; mask_last = 0;
    @(negedge clk); @(negedge clk);
    check("R7 reset word", out_word, 16'h0);
    check("R7 reset valid", {15'd0, out_valid}, 16'h0);
    rst = 0;

    // load pattern rows (R8)
    for (int i = 0; i < 16; i++) begin
      pat[i] = 16'($urandom);
      pat_we = 1; pat_addr = 4'(i); pat_wdata = pat[i];
      @(negedge clk);
    end
    pat_we = 0;

    // R3: every code, operands covering all four (H,D) pairs
    mask_first = 16'hFFFF; mask_mid = 16'hFFFF; mask_last = 16'hFFFF;
    ht_sel = 2'd2; src_word = 16'hFF00; dst_word = 16'hF0F0;
    for (int c = 0; c < 16; c++) begin
      rop = 4'(c);
      run_word("R3 rop code", ref_word());
    end

    // R1: each pattern select
    rop = 4'h3; line_idx = 4'd5; src_word = 16'h3C5A;
    for (int s = 0; s < 4; s++) begin
      ht_sel = 2'(s);
      run_word("R1 pattern select", ref_word());
    end

    // R2: smudge uses source low bits, differing from line_idx
    ht_sel = 2'd1; line_idx = 4'd2; src_word = 16'h12A9; smudge = 1;
    run_word("R2 smudge index", pat[9]);
    smudge = 0;
    run_word("R2 line index", pat[2]);

    // R4/R5: mask position choice, overlap priority
    rop = 4'hF; ht_sel = 2'd0; dst_word = 16'h0000;
    mask_first = 16'h00FF; mask_mid = 16'h0FF0; mask_last = 16'hF000;
    first_word = 1; last_word = 1;
    run_word("R4 one-word line uses first mask", 16'h00FF);
    first_word = 0;
    run_word("R4 last mask", 16'hF000);
    last_word = 0;
    run_word("R4 middle mask", 16'h0FF0);
    rop = 4'h0; dst_word = 16'hFFFF;
    run_word("R5 merge keeps outside bits", 16'hF00F);

    // R6: output holds while idle
    @(negedge clk); dst_word = 16'h1234;
    @(negedge clk);
    check("R6 hold word", out_word, 16'hF00F);
    check("R6 idle valid", {15'd0, out_valid}, 16'h0);

    // R8: same-cycle write reads old row, next cycle reads new
    ht_sel = 2'd1; rop = 4'h3; smudge = 0; line_idx = 4'd7;
    mask_mid = 16'hFFFF;
    pat_we = 1; pat_addr = 4'd7; pat_wdata = ~pat[7];
    run_word("R8 same-cycle old row", pat[7]);
    pat_we = 0; pat[7] = ~pat[7];
    run_word("R8 new row visible", pat[7]);

    // random mix
    for (int n = 0; n < 400; n++) begin
      src_word = 16'($urandom); dst_word = 16'($urandom);
      line_idx = 4'($urandom); smudge = 1'($urandom);
      ht_sel = 2'($urandom); rop = 4'($urandom);
      first_word = 1'($urandom); last_word = 1'($urandom);
      mask_first = 16'($urandom); mask_mid = 16'($urandom);
      mask_last = 16'($urandom);
      run_word("R1 R2 R3 R4 R5 random", ref_word());
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule